// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is an I2C bus master that software drives one byte at a time through two registers: a control/status register and a data register. Software first arms a start by setting a control bit. The next write to the data register then puts a start condition on the bus and shifts out the written byte as the slave address plus direction bit. After that, each write to the data register sends one more byte without a new start. When a byte ends, the engine latches the slave's acknowledge and raises a completion flag. That flag can also drive a level interrupt request.

Between bytes the engine holds SCL low. Software ends the transfer by setting the stop bit. It does so after the last byte, or at once on a missing acknowledge or a bus error. The engine watches SDA whenever it has released the line and SCL is high. If another device holds SDA low at such a moment, the cause is contention or lost arbitration. The engine then flags a bus error, releases both lines and goes idle. Both pins are open-drain: each is an enable that pulls the line low, and SDA is also read back. SCL runs at a fixed rate derived from the system clock. Each bit takes four quarter periods.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line enables are low, the interrupt is low and the control/status register reads 0x00.
- R2: With the start bit (bit 0) armed in idle, a data write produces a start condition (SDA falls while SCL is high), then the byte MSB first, then a ninth clock. The start bit reads 0 from the cycle after that write.
- R3: A data write while idle with the start bit clear causes no bus activity and sets no flag.
- R4: On the falling edge that ends the ninth clock, DONE (bit 5) and ACK (bit 6) update in the same cycle. ACK reads 1 when SDA was low at the ninth clock and 0 when it was high.
- R5: Reading or writing the data register clears DONE. A write while the engine is holding after a byte sends the next byte with no start condition. A read returns the last written byte.
- R6: If SDA reads low while the engine has it released with SCL high, BERR (bit 7) is set and DONE is not. This covers the start check and data bits 7..0. Both line enables then drop and the engine stays idle.
- R7: Any read or write of the data register clears BERR.
- R8: Setting the stop bit (bit 1) while holding produces a stop condition (SDA rises while SCL is high) and releases both lines. If the stop bit is set while idle, it clears within a few cycles. In both cases the stop bit self-clears.
- R9: The interrupt output is high exactly while DONE and the interrupt enable (bit 2) are both set.
- R10: In every data or acknowledge bit, SCL is high for 2 quarter periods and the SDA enable does not change while SCL is high. The start pulse from idle or hold is 3 quarter periods high.
- R11: With the start bit armed while holding, a data write produces a repeated start condition before the byte.
- R12: Control writes store only bits 0..2. Bits 5..7 are read-only status, and bits 3 and 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 control/status, 1 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Embedded assertions check on every cycle that:
- DONE and ACK update together;
- an access to the data register clears DONE and BERR;
- the interrupt follows completion;
- SDA stays stable while SCL is high inside a bit;
- an error releases both lines;
- a finished byte leaves SCL held low.

Only the bench scenarios can show the bus-level behaviour: the bytes a slave actually receives, where start and stop conditions fall, the ACK and NACK outcomes, quarter-period pulse widths, and the absence of bus activity on an unarmed write. The two error paths, contention at start and lost arbitration mid-byte, are also shown only by these scenarios.

// File: rtl/i2c_bm_pkg.sv
// Shared definitions for the I2C byte master: engine states, register
// field positions and register select codes.
// Assumes 8-bit bytes on the bus and a single register access per cycle.
package i2c_bm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_START,
        EN_BITS,
        EN_HOLD,
        EN_STOP
    } eng_state_t;

    localparam int CTL_START = 0;
    localparam int CTL_STOP  = 1;
    localparam int CTL_IE    = 2;
    localparam int STS_DONE  = 5;
    localparam int STS_ACK   = 6;
    localparam int STS_BERR  = 7;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/i2c_bm_qtick.sv
// Quarter-period tick generator for SCL timing.
// Counts system clocks only while run is high and restarts from zero each
// time run rises, so the first quarter after a launch is full length.
// Assumes QTR >= 2.
module i2c_bm_qtick #(
    parameter int QTR = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR > 2) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt;

    // Free-running divider, held at zero while the engine is parked.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    // Two ticks are never adjacent, so each quarter lasts at least two clocks.
    p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/i2c_bm_regs.sv
// Control/status and data registers of the I2C byte master.
// Control bits: arm start, request stop, interrupt enable (writable).
// Status bits: done, ack, bus error (set by the engine, cleared by any
// data-register access). Assumes at most one access per cycle.
module i2c_bm_regs
    import i2c_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              byte_done,
    input  logic              ack_val,
    input  logic              berr_evt,
    input  logic              start_taken,
    input  logic              stop_clear,
    output logic              start_arm,
    output logic              stop_req,
    output logic              irq
);
    logic              ie_q, done_q, ack_q, berr_q;
    logic [BYTE_W-1:0] data_q;
    logic              ctrl_wr, data_wr, data_acc;

    assign ctrl_wr  = bus_wr && (bus_sel == SEL_CTRL);
    assign data_wr  = bus_wr && (bus_sel == SEL_DATA);
    assign data_acc = (bus_wr || bus_rd) && (bus_sel == SEL_DATA);

    // Start arm: written by software, consumed when the engine launches.
    always_ff @(posedge clk) begin
        if (!rst_n) start_arm <= 1'b0;
        else if (ctrl_wr) start_arm <= bus_wdata[CTL_START];
        else if (start_taken) start_arm <= 1'b0;
    end

    // Stop request: set-only by software, cleared once the engine serviced it.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_req <= 1'b0;
        else if (ctrl_wr && bus_wdata[CTL_STOP]) stop_req <= 1'b1;
        else if (stop_clear) stop_req <= 1'b0;
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else if (ctrl_wr) ie_q <= bus_wdata[CTL_IE];
    end

    // Completion flag and acknowledge, updated together at byte end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ack_q  <= 1'b0;
        end else if (byte_done) begin
            done_q <= 1'b1;
            ack_q  <= ack_val;
        end else if (data_acc) begin
            done_q <= 1'b0;
        end
    end

    // Bus error flag: set by the engine, cleared by data-register access.
    always_ff @(posedge clk) begin
        if (!rst_n) berr_q <= 1'b0;
        else if (berr_evt) berr_q <= 1'b1;
        else if (data_acc) berr_q <= 1'b0;
    end

    // Last byte written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (data_wr) data_q <= bus_wdata;
    end

    // Read multiplexer for the two registers.
    always_comb begin
        if (bus_sel == SEL_DATA) begin
            bus_rdata = data_q;
        end else begin
            bus_rdata            = '0;
            bus_rdata[CTL_START] = start_arm;
            bus_rdata[CTL_STOP]  = stop_req;
            bus_rdata[CTL_IE]    = ie_q;
            bus_rdata[STS_DONE]  = done_q;
            bus_rdata[STS_ACK]   = ack_q;
            bus_rdata[STS_BERR]  = berr_q;
        end
    end

    assign irq = ie_q && done_q;

    p_done_ack_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (done_q && (ack_q == $past(ack_val))));

    p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !byte_done) |=> !done_q);

    p_berr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !berr_evt) |=> !berr_q);

    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ie_q && !ctrl_wr) |=> irq);

endmodule

// File: rtl/i2c_bm_engine.sv
// Bit-level I2C master engine. Generates start, eight data bits plus an
// acknowledge clock, holds SCL low between bytes, and generates stop.
// Each bit is four quarters: SCL low for quarters 0-1 (SDA updated at the
// start of quarter 1), high for quarters 2-3 (SDA sampled at end of
// quarter 2). Assumes no clock stretching by slaves.
module i2c_bm_engine
    import i2c_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              launch_req,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              start_arm,
    input  logic              stop_req,
    input  logic              sda_in,
    output logic              run,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              byte_done,
    output logic              ack_val,
    output logic              berr_evt,
    output logic              start_taken,
    output logic              stop_clear
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] ACK_BIT = BCW'(BYTE_W);

    eng_state_t        st;
    logic [1:0]        q;
    logic [BCW-1:0]    bitn;
    logic [BYTE_W-1:0] sh;
    logic              sda_drv;
    logic              ack_q;
    logic              accept;

    // A data write is accepted from idle with start armed, or while holding.
    assign accept = launch_req &&
                    (((st == EN_IDLE) && start_arm) || ((st == EN_HOLD) && !stop_req));
    assign start_taken = accept && start_arm;

    // Released SDA read low while SCL is high: contention or lost arbitration.
    assign berr_evt = tick &&
        (((st == EN_START) && (q == 2'd1) && !sda_in) ||
         ((st == EN_BITS) && (q == 2'd2) && (bitn < ACK_BIT) && !sda_drv && !sda_in));

    assign byte_done  = tick && (st == EN_BITS) && (q == 2'd3) && (bitn == ACK_BIT);
    assign stop_clear = (tick && (st == EN_STOP) && (q == 2'd3)) ||
                        ((st == EN_IDLE) && stop_req);
    assign ack_val    = ack_q;
    assign run        = (st == EN_START) || (st == EN_BITS) || (st == EN_STOP);
    assign sda_oe     = sda_drv;

    // SCL drive as a function of state and quarter.
    always_comb begin
        unique case (st)
            EN_IDLE:  scl_oe = 1'b0;
            EN_HOLD:  scl_oe = 1'b1;
            EN_START: scl_oe = (q == 2'd0);
            default:  scl_oe = !q[1];
        endcase
    end

    // Sequencer: state, quarter, bit count, shift register and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= EN_IDLE;
            q       <= 2'd0;
            bitn    <= '0;
            sh      <= '0;
            sda_drv <= 1'b0;
            ack_q   <= 1'b0;
        end else if (berr_evt) begin
            st      <= EN_IDLE;
            q       <= 2'd0;
            sda_drv <= 1'b0;
        end else begin
            unique case (st)
                EN_IDLE: begin
                    if (accept) begin
                        st   <= EN_START;
                        q    <= 2'd0;
                        bitn <= '0;
                        sh   <= wdata;
                    end
                end
                EN_HOLD: begin
                    if (stop_req) begin
                        st <= EN_STOP;
                        q  <= 2'd0;
                    end else if (accept) begin
                        st   <= start_arm ? EN_START : EN_BITS;
                        q    <= 2'd0;
                        bitn <= '0;
                        sh   <= wdata;
                    end
                end
                EN_START: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd1) sda_drv <= 1'b1;
                        if (q == 2'd3) st <= EN_BITS;
                    end
                end
                EN_BITS: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd0) sda_drv <= (bitn < ACK_BIT) ? !sh[BYTE_W-1] : 1'b0;
                        if ((q == 2'd2) && (bitn == ACK_BIT)) ack_q <= !sda_in;
                        if (q == 2'd3) begin
                            if (bitn == ACK_BIT) begin
                                st <= EN_HOLD;
                            end else begin
                                sh   <= sh << 1;
                                bitn <= bitn + 1'b1;
                            end
                        end
                    end
                end
                EN_STOP: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd0) sda_drv <= 1'b1;
                        if (q == 2'd2) sda_drv <= 1'b0;
                        if (q == 2'd3) st <= EN_IDLE;
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EN_IDLE) |-> (!scl_oe && !sda_drv));

    p_sda_stable_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == EN_BITS) && ($past(st) == EN_BITS) && !scl_oe && !$past(scl_oe))
        |-> $stable(sda_drv));

    p_berr_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        berr_evt |=> ((st == EN_IDLE) && !sda_drv && !scl_oe));

    p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> ((st == EN_HOLD) && scl_oe));

endmodule

// File: rtl/i2c_byte_master.sv
// Top of the register-driven I2C byte master. Ties the register block,
// the quarter-period tick generator and the bit engine together.
// Assumes CLK_HZ >= 8 * SCL_HZ so each quarter is at least two clocks.
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    localparam int QTR = CLK_HZ / (4 * SCL_HZ);

    logic tick, run;
    logic byte_done, ack_val, berr_evt, start_taken, stop_clear;
    logic start_arm, stop_req;
    logic launch_req;

    assign launch_req = bus_wr && (bus_sel == SEL_DATA);

    i2c_bm_qtick #(.QTR(QTR)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    i2c_bm_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .byte_done   (byte_done),
        .ack_val     (ack_val),
        .berr_evt    (berr_evt),
        .start_taken (start_taken),
        .stop_clear  (stop_clear),
        .start_arm   (start_arm),
        .stop_req    (stop_req),
        .irq         (irq)
    );

    i2c_bm_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .launch_req  (launch_req),
        .wdata       (bus_wdata),
        .start_arm   (start_arm),
        .stop_req    (stop_req),
        .sda_in      (sda_in),
        .run         (run),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .byte_done   (byte_done),
        .ack_val     (ack_val),
        .berr_evt    (berr_evt),
        .start_taken (start_taken),
        .stop_clear  (stop_clear)
    );

endmodule

// File: tb/i2c_byte_master_bench.sv
// Bench: software-style register accesses, a behavioural slave/bus monitor
// decoding the open-drain lines every clock, and expected values derived
// from the requirements.
module i2c_byte_master_bench;
    localparam int CLK_HZ = 50_000_000;
    localparam int SCL_HZ = 2_500_000;
    localparam int QTR    = CLK_HZ / (4 * SCL_HZ);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slave_pull = 1'b0, jam = 1'b0, ack_en = 1'b1;
    logic       scl_line, sda_line;

    always #10 clk = ~clk;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slave_pull || jam);

    i2c_byte_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    int nchecks = 0;
    int nfail   = 0;
    int cyc     = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Behavioural slave and bus monitor, sampled away from the active edge.
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic       st_flag = 1'b0;
    logic [7:0] shreg = 8'h00;
    int         bitcnt = 0, hi_cnt = 1000;
    int         n_start = 0, n_stop = 0, n_fall = 0, n_w2 = 0, n_w3 = 0, n_wbad = 0;
    logic [8:0] rxq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line) hi_cnt = prev_scl ? hi_cnt + 1 : 1;
            if (scl_line && prev_scl && prev_sda && !sda_line) begin
                n_start++; bitcnt = 0; st_flag = 1'b1;
            end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
                n_stop++; bitcnt = 0;
            end
            if (scl_line && !prev_scl) begin
                if (bitcnt < 8) begin
                    shreg = {shreg[6:0], sda_line};
                    if (bitcnt == 7) begin
                        rxq.push_back({st_flag, shreg});
                        st_flag = 1'b0;
                    end
                end
                bitcnt++;
            end
            if (!scl_line && prev_scl) begin
                n_fall++;
                if (hi_cnt < 4 * QTR) begin
                    if (hi_cnt == 2 * QTR) n_w2++;
                    else if (hi_cnt == 3 * QTR) n_w3++;
                    else n_wbad++;
                end
                if (bitcnt == 8 && ack_en) slave_pull = 1'b1;
                else if (bitcnt == 9) begin
                    slave_pull = 1'b0; bitcnt = 0;
                end
            end
            prev_scl = scl_line;
            prev_sda = sda_line;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            nchecks++; nfail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Poll status until DONE (bit 5) or BERR (bit 7).
    task automatic wait_evt(output logic [7:0] s);
        s = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            bus_read(1'b0, s);
            if (s[5] || s[7]) break;
        end
    endtask

    logic [7:0] v;
    logic [8:0] got;
    int         s0;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(1'b0, v);
        chk("R1 status after reset", v, 8'h00);
        chk("R1 lines released", {scl_oe, sda_oe, irq}, 3'b000);

        // R12 only bits 0..2 writable
        bus_write(1'b0, 8'hE4);
        bus_read(1'b0, v);
        chk("R12 ctrl readback", v, 8'h04);

        // R3 unarmed data write: no bus activity
        bus_write(1'b1, 8'h99);
        repeat (100) @(negedge clk);
        chk("R3 no SCL activity", n_fall, 0);
        bus_read(1'b0, v);
        chk("R3 no flags set", v, 8'h04);

        // R2 armed start plus address byte
        bus_write(1'b0, 8'h05);
        bus_write(1'b1, 8'hA4);
        bus_read(1'b0, v);
        chk("R2 start bit consumed", v[0], 1'b0);
        wait_evt(v);
        got = (rxq.size() > 0) ? rxq.pop_front() : 9'h000;
        chk("R2 start plus byte received", got, 9'h1A4);
        chk("R2 one start seen", n_start, 1);
        chk("R4 done and ack set", v, 8'h64);
        chk("R9 irq with done and enable", irq, 1'b1);

        // R5 next byte, done cleared by write, no new start
        bus_write(1'b1, 8'h3C);
        bus_read(1'b0, v);
        chk("R5 done cleared by write", v[5], 1'b0);
        chk("R9 irq drops with done", irq, 1'b0);
        wait_evt(v);
        got = (rxq.size() > 0) ? rxq.pop_front() : 9'h000;
        chk("R5 second byte without start", got, 9'h03C);
        chk("R5 still one start", n_start, 1);

        // R4 NACK
        ack_en = 1'b0;
        bus_write(1'b1, 8'h81);
        wait_evt(v);
        chk("R4 nack done=1 ack=0", {v[6], v[5]}, 2'b01);
        got = (rxq.size() > 0) ? rxq.pop_front() : 9'h000;
        chk("R4 nack byte received", got, 9'h081);
        ack_en = 1'b1;

        // R11 repeated start
        bus_write(1'b0, 8'h05);
        bus_write(1'b1, 8'hA5);
        wait_evt(v);
        got = (rxq.size() > 0) ? rxq.pop_front() : 9'h000;
        chk("R11 repeated start byte", got, 9'h1A5);
        chk("R11 two starts", n_start, 2);

        // R5 data read clears done and returns last byte
        bus_read(1'b1, v);
        chk("R5 data readback", v, 8'hA5);
        bus_read(1'b0, v);
        chk("R5 done cleared by read", v[5], 1'b0);

        // R8 stop from hold
        bus_write(1'b0, 8'h06);
        for (int i = 0; i < 200; i++) begin
            bus_read(1'b0, v);
            if (!v[1]) break;
        end
        chk("R8 stop bit self-clears", v[1], 1'b0);
        chk("R8 stop condition seen", n_stop, 1);
        chk("R8 lines released", {scl_oe, sda_oe}, 2'b00);

        // R10 pulse widths: 4 bytes x 9 clocks at 2Q, 2 starts at 3Q
        chk("R10 no odd SCL pulses", n_wbad, 0);
        chk("R10 data clock count", n_w2, 36);
        chk("R10 start pulse count", n_w3, 2);

        // R6 contention at start
        jam = 1'b1;
        bus_write(1'b0, 8'h05);
        bus_write(1'b1, 8'h55);
        wait_evt(v);
        chk("R6 berr at start, no done", {v[7], v[5]}, 2'b10);
        repeat (4) @(negedge clk);
        chk("R6 lines released", {scl_oe, sda_oe}, 2'b00);
        jam = 1'b0;
        @(negedge clk);

        // R7 data read clears berr
        bus_read(1'b1, v);
        bus_read(1'b0, v);
        chk("R7 berr cleared by read", v[7], 1'b0);

        // R6 lost arbitration in a data bit
        s0 = n_start;
        bus_write(1'b0, 8'h05);
        bus_write(1'b1, 8'hFF);
        for (int i = 0; i < 500 && n_start == s0; i++) @(negedge clk);
        for (int i = 0; i < 100 && scl_line; i++) @(negedge clk);
        jam = 1'b1;
        wait_evt(v);
        chk("R6 berr mid-byte, no done", {v[7], v[5]}, 2'b10);
        jam = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 released after arbitration loss", {scl_oe, sda_oe}, 2'b00);

        // R8 stop while idle clears quickly
        bus_write(1'b0, 8'h02);
        repeat (3) @(negedge clk);
        bus_read(1'b0, v);
        chk("R8 idle stop clears", v[1], 1'b0);

        // R7 data write clears berr (unarmed, so no bus activity)
        bus_write(1'b1, 8'h00);
        bus_read(1'b0, v);
        chk("R7 berr cleared by write", v[7], 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule